// File: doc/BRIEF.md
# Dual Prefetch Buffer Controller

This block sits between a code cache and an instruction decoder and keeps the decoder supplied with instruction bytes. It owns two 32-byte line buffers. Only one of them is filled at any time: it takes whole cache lines at consecutive aligned addresses, and each line is written in a single clock. This continues until a filled line contains a branch that the branch target buffer predicts as taken. At that point the line is cut off just after the branch. Filling moves to the other buffer, which loads the line that holds the predicted target and starts reading at the target's byte position. The decoder keeps reading the old buffer up to the branch. In the cycle after the last byte before the branch is consumed, reading moves to the new buffer.

The branch lookup is driven by the address currently being requested and is sampled in the same cycle as the cache response. The decoder sees a window of up to 16 bytes starting at the read pointer and reports back how many of them it consumed. An external redirect, raised by a misprediction, empties both buffers and restarts fetching at the corrected address in buffer 0.

Top module: `dual_prefetch_ctl`

## Requirements
- R1: After reset, req_valid is 1 with req_addr equal to the RESET_ADDR parameter (default 0), and dec_valid is 0.
- R2: A request waiting for the cache keeps req_valid at 1 and req_addr unchanged for as long as rsp_valid is 0. A line is written into the buffer being filled at the clock edge where both req_valid and rsp_valid are 1. Byte k of the line is rsp_data[8k+7:8k].
- R3: req_valid is 0 whenever the buffer currently being filled still holds unconsumed bytes. A line is accepted only into an empty buffer.
- R4: A line accepted without a usable taken prediction is valid for all 32 bytes. The next request is req_addr + 32 for the same buffer.
- R5: dec_count is min(16, limit - read pointer) of the reading buffer, or 0 when that buffer is empty. dec_valid is 1 exactly when dec_count is nonzero. Byte j of dec_bytes (bits 8j+7:8j) is line byte (read pointer + j) for j < dec_count, and is 0 above that.
- R6: At each clock, dec_consume (assumed to be no more than dec_count) advances the read pointer. When the pointer reaches the buffer's limit, the buffer becomes empty.
- R7: A usable taken prediction arrives with the line: btb_hit and btb_taken are both 1, and btb_brk_off is at least the line's entry offset. The line's limit is then btb_brk_off + 1, where btb_brk_off is the byte offset of the branch's last byte. The next request is for the line that contains btb_target, filled into the other buffer, while the old bytes stay readable.
- R8: The first line filled after a taken prediction starts with its read pointer at btb_target[4:0].
- R9: When a buffer that ends in a predicted branch is drained, the output comes from the other buffer in the very next cycle.
- R10: A BTB hit that is not taken, or a taken prediction whose btb_brk_off is below the entry offset, is treated as sequential under R4.
- R11: A redirect empties both buffers and drops any cache response in the same cycle. It restarts filling in buffer 0 at the line that holds redirect_addr, and that line is read from offset redirect_addr[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | output | 1 | Line request to the code cache |
| req_addr | output | 32 | 32-byte aligned line address, also the BTB lookup address |
| rsp_valid | input | 1 | Cache returns the requested line this cycle |
| rsp_data | input | 256 | Returned line, byte k at bits 8k+7:8k |
| btb_hit | input | 1 | BTB has an entry for the requested line |
| btb_taken | input | 1 | The entry predicts taken |
| btb_target | input | 32 | Predicted target byte address |
| btb_brk_off | input | 5 | Offset of the branch's last byte within the line |
| dec_valid | output | 1 | At least one byte is presented |
| dec_bytes | output | 128 | Byte window starting at the read pointer |
| dec_count | output | 5 | Number of valid bytes in dec_bytes (0 to 16) |
| dec_consume | input | 5 | Bytes taken by the decoder at this edge |
| redirect | input | 1 | Misprediction restart |
| redirect_addr | input | 32 | Corrected fetch byte address |

## Verification
A wrong read pointer or limit shows up in the next cycle as shifted bytes in dec_bytes or a wrong dec_count. A wrong choice of fill buffer or a wrong empty flag shows up at once as req_valid being high while a buffer still holds bytes, or low while it is waiting. A wrong next fetch address appears on req_addr in the cycle after the line is accepted. A handoff to the wrong buffer appears in the cycle after the branch line drains, as bytes from the wrong address or a dec_count of zero.

// File: rtl/pfb_pkg.sv
// Shared defaults and helpers for the dual prefetch buffer controller.
// Assumes byte-addressed fetch with power-of-two line size.
package pfb_pkg;
    localparam int LINE_BYTES_DEF = 32;
    localparam int OUT_BYTES_DEF  = 16;
    localparam int ADDR_W_DEF     = 32;

    // Which of the two buffers a side currently uses.
    typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_sel_e;
endpackage

// File: rtl/pfb_line_buf.sv
// One 32-byte line buffer: holds a line, a read pointer and a limit
// (bytes at or above the limit are not presented). Assumes a fill only
// arrives while empty and advance only while valid.
module pfb_line_buf #(
    parameter int LINE_BYTES = pfb_pkg::LINE_BYTES_DEF,
    parameter int OUT_BYTES  = pfb_pkg::OUT_BYTES_DEF,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LIM_W     = OFF_W + 1,
    localparam int CNT_W     = $clog2(OUT_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 fill_en,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic [OFF_W-1:0]     fill_off,
    input  logic [LIM_W-1:0]     fill_lim,
    input  logic                 fill_brk,
    input  logic                 adv_en,
    input  logic [CNT_W-1:0]     adv_cnt,
    output logic                 vld,
    output logic [OFF_W-1:0]     rd,
    output logic [LIM_W-1:0]     lim,
    output logic                 brk,
    output logic [LINE_BITS-1:0] data,
    output logic                 drained
);
    logic [LIM_W-1:0] next_pos;

    // Position after this cycle's consumption.
    always_comb next_pos = {1'b0, rd} + LIM_W'(adv_cnt);

    // Drain event: the last byte below the limit is consumed.
    always_comb drained = adv_en && vld && (next_pos >= lim);

    // Control state: valid flag, pointer, limit, branch-end flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld <= 1'b0;
            rd  <= '0;
            lim <= '0;
            brk <= 1'b0;
        end else if (fill_en) begin
            vld <= 1'b1;
            rd  <= fill_off;
            lim <= fill_lim;
            brk <= fill_brk;
        end else if (drained) begin
            vld <= 1'b0;
        end else if (adv_en && vld) begin
            rd <= next_pos[OFF_W-1:0];
        end
    end

    // Line storage: written whole in one clock.
    always_ff @(posedge clk) begin
        if (fill_en) data <= fill_data;
    end
endmodule

// File: rtl/pfb_fetch_ctl.sv
// Fill-side sequencer: which buffer is filled next, which line is requested
// and at what offset that line will be entered. Redirect has priority.
module pfb_fetch_ctl #(
    parameter int          ADDR_W     = pfb_pkg::ADDR_W_DEF,
    parameter int          LINE_BYTES = pfb_pkg::LINE_BYTES_DEF,
    parameter logic [31:0] RESET_ADDR = 32'h0,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              fill_go,
    input  logic              take_jump,
    input  logic [ADDR_W-1:0] jump_addr,
    output pfb_pkg::buf_sel_e fill_buf,
    output logic [ADDR_W-1:0] line_addr,
    output logic [OFF_W-1:0]  entry_off
);
    logic [LINE_W-1:0] line_q;
    localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_ADDR);

    // Present the current line as an aligned byte address.
    always_comb line_addr = {line_q, {OFF_W{1'b0}}};

    // Advance the line pointer, switch buffers on a usable taken prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_buf  <= pfb_pkg::BUF_A;
            line_q    <= RST_A[ADDR_W-1:OFF_W];
            entry_off <= RST_A[OFF_W-1:0];
        end else if (redirect) begin
            fill_buf  <= pfb_pkg::BUF_A;
            line_q    <= redirect_addr[ADDR_W-1:OFF_W];
            entry_off <= redirect_addr[OFF_W-1:0];
        end else if (fill_go && take_jump) begin
            fill_buf  <= (fill_buf == pfb_pkg::BUF_A) ? pfb_pkg::BUF_B : pfb_pkg::BUF_A;
            line_q    <= jump_addr[ADDR_W-1:OFF_W];
            entry_off <= jump_addr[OFF_W-1:0];
        end else if (fill_go) begin
            line_q    <= line_q + 1'b1;
            entry_off <= '0;
        end
    end
endmodule

// File: rtl/pfb_read_sel.sv
// Read side: tracks which buffer feeds the decoder, hands over when a
// branch-terminated buffer drains, and builds the masked byte window.
module pfb_read_sel #(
    parameter int LINE_BYTES = pfb_pkg::LINE_BYTES_DEF,
    parameter int OUT_BYTES  = pfb_pkg::OUT_BYTES_DEF,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int OUT_BITS  = OUT_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LIM_W     = OFF_W + 1,
    localparam int CNT_W     = $clog2(OUT_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 redirect,
    input  logic [1:0]           vld,
    input  logic [1:0]           brk,
    input  logic [1:0]           drained,
    input  logic [OFF_W-1:0]     rd0,
    input  logic [OFF_W-1:0]     rd1,
    input  logic [LIM_W-1:0]     lim0,
    input  logic [LIM_W-1:0]     lim1,
    input  logic [LINE_BITS-1:0] data0,
    input  logic [LINE_BITS-1:0] data1,
    output pfb_pkg::buf_sel_e    read_buf,
    output logic [OUT_BITS-1:0]  win_bytes,
    output logic [CNT_W-1:0]     win_count
);
    logic                 s_vld;
    logic [OFF_W-1:0]     s_rd;
    logic [LIM_W-1:0]     s_lim;
    logic [LINE_BITS-1:0] s_data;
    logic [LINE_BITS-1:0] shifted;
    logic [LIM_W-1:0]     avail;

    // Hand over to the other buffer when a branch-ended buffer drains.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            read_buf <= pfb_pkg::BUF_A;
        end else if (drained[read_buf] && brk[read_buf]) begin
            read_buf <= (read_buf == pfb_pkg::BUF_A) ? pfb_pkg::BUF_B : pfb_pkg::BUF_A;
        end
    end

    // Select the reading buffer's state.
    always_comb begin
        s_vld  = vld[read_buf];
        s_rd   = (read_buf == pfb_pkg::BUF_A) ? rd0   : rd1;
        s_lim  = (read_buf == pfb_pkg::BUF_A) ? lim0  : lim1;
        s_data = (read_buf == pfb_pkg::BUF_A) ? data0 : data1;
    end

    // Count of presentable bytes, clipped to the window width.
    always_comb begin
        avail = s_lim - {1'b0, s_rd};
        if (!s_vld)
            win_count = '0;
        else if (avail >= LIM_W'(OUT_BYTES))
            win_count = CNT_W'(OUT_BYTES);
        else
            win_count = CNT_W'(avail);
    end

    // Align the line so the read pointer lands on byte 0.
    always_comb shifted = s_data >> {s_rd, 3'b000};

    // Zero every window byte at or above the count.
    for (genvar j = 0; j < OUT_BYTES; j++) begin : g_mask
        localparam logic [CNT_W-1:0] JV = CNT_W'(j);
        assign win_bytes[8*j +: 8] = (JV < win_count) ? shifted[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/dual_prefetch_ctl.sv
// Top of the dual prefetch buffer controller. Two line buffers in
// ping-pong: one is filled from the cache at a time, a usable taken BTB
// prediction moves filling to the other buffer at the target line.
// Assumes the BTB answers combinationally for req_addr and dec_consume
// never exceeds dec_count.
module dual_prefetch_ctl #(
    parameter int          ADDR_W     = pfb_pkg::ADDR_W_DEF,
    parameter int          LINE_BYTES = pfb_pkg::LINE_BYTES_DEF,
    parameter int          OUT_BYTES  = pfb_pkg::OUT_BYTES_DEF,
    parameter logic [31:0] RESET_ADDR = 32'h0,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int OUT_BITS  = OUT_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LIM_W     = OFF_W + 1,
    localparam int CNT_W     = $clog2(OUT_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 req_valid,
    output logic [ADDR_W-1:0]    req_addr,
    input  logic                 rsp_valid,
    input  logic [LINE_BITS-1:0] rsp_data,
    input  logic                 btb_hit,
    input  logic                 btb_taken,
    input  logic [ADDR_W-1:0]    btb_target,
    input  logic [OFF_W-1:0]     btb_brk_off,
    output logic                 dec_valid,
    output logic [OUT_BITS-1:0]  dec_bytes,
    output logic [CNT_W-1:0]     dec_count,
    input  logic [CNT_W-1:0]     dec_consume,
    input  logic                 redirect,
    input  logic [ADDR_W-1:0]    redirect_addr
);
    pfb_pkg::buf_sel_e    fill_buf;
    pfb_pkg::buf_sel_e    read_buf;
    logic [OFF_W-1:0]     entry_off;
    logic                 fill_go;
    logic                 take_jump;
    logic [LIM_W-1:0]     fill_lim;
    logic [1:0]           vld, brk, drained;
    logic [OFF_W-1:0]     rd   [2];
    logic [LIM_W-1:0]     lim  [2];
    logic [LINE_BITS-1:0] data [2];

    // Request while the fill buffer is empty and no restart is under way.
    always_comb req_valid = !vld[fill_buf] && !redirect;

    // Line accepted this cycle.
    always_comb fill_go = req_valid && rsp_valid;

    // Prediction is usable only if the branch lies at or after the entry point.
    always_comb take_jump = btb_hit && btb_taken && (btb_brk_off >= entry_off);

    // Limit: cut after the branch's last byte, else the whole line.
    always_comb fill_lim = take_jump ? ({1'b0, btb_brk_off} + 1'b1) : LIM_W'(LINE_BYTES);

    pfb_fetch_ctl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .redirect(redirect), .redirect_addr(redirect_addr),
        .fill_go(fill_go), .take_jump(take_jump), .jump_addr(btb_target),
        .fill_buf(fill_buf), .line_addr(req_addr), .entry_off(entry_off)
    );

    for (genvar i = 0; i < 2; i++) begin : g_buf
        pfb_line_buf #(.LINE_BYTES(LINE_BYTES), .OUT_BYTES(OUT_BYTES)) u_buf (
            .clk(clk), .rst_n(rst_n), .flush(redirect),
            .fill_en(fill_go && (fill_buf == pfb_pkg::buf_sel_e'(i))),
            .fill_data(rsp_data), .fill_off(entry_off),
            .fill_lim(fill_lim), .fill_brk(take_jump),
            .adv_en((read_buf == pfb_pkg::buf_sel_e'(i)) && !redirect),
            .adv_cnt(dec_consume),
            .vld(vld[i]), .rd(rd[i]), .lim(lim[i]), .brk(brk[i]),
            .data(data[i]), .drained(drained[i])
        );
    end

    pfb_read_sel #(.LINE_BYTES(LINE_BYTES), .OUT_BYTES(OUT_BYTES)) u_read (
        .clk(clk), .rst_n(rst_n), .redirect(redirect),
        .vld(vld), .brk(brk), .drained(drained),
        .rd0(rd[0]), .rd1(rd[1]), .lim0(lim[0]), .lim1(lim[1]),
        .data0(data[0]), .data1(data[1]),
        .read_buf(read_buf), .win_bytes(dec_bytes), .win_count(dec_count)
    );

    // Window is valid exactly when it holds bytes.
    always_comb dec_valid = (dec_count != '0);
endmodule

// File: rtl/pfb_checker.sv
// Port-level properties of the dual prefetch buffer controller, bound to the top.
module pfb_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int OUT_BYTES  = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CNT_W     = $clog2(OUT_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              btb_hit,
    input logic              btb_taken,
    input logic              dec_valid,
    input logic [CNT_W-1:0]  dec_count,
    input logic              redirect,
    input logic [ADDR_W-1:0] redirect_addr
);
    // R2: an unanswered request holds its address.
    p_hold_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_valid && !redirect |=> req_valid && req_addr == $past(req_addr));

    // R4: no taken prediction, so the next line follows on.
    p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && !redirect && !(btb_hit && btb_taken)
        |=> req_addr == $past(req_addr) + ADDR_W'(LINE_BYTES));

    // R11: a restart empties the output and requests the corrected line.
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !dec_valid && req_valid
        && req_addr[ADDR_W-1:OFF_W] == $past(redirect_addr[ADDR_W-1:OFF_W]));

    // R5: the window never exceeds its width.
    p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_count <= CNT_W'(OUT_BYTES));

    // R5: valid follows a nonzero count.
    p_valid_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == (dec_count != '0));

    // R3: a line just accepted into the fill buffer blocks an immediate repeat
    // unless it carried a taken prediction (which switches buffers).
    p_no_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && !redirect && !btb_hit |=> !req_valid);
endmodule

bind dual_prefetch_ctl pfb_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .OUT_BYTES(OUT_BYTES)
) u_pfb_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .btb_hit(btb_hit), .btb_taken(btb_taken),
    .dec_valid(dec_valid), .dec_count(dec_count),
    .redirect(redirect), .redirect_addr(redirect_addr)
);

// File: tb/tb_dual_prefetch_ctl.sv
// Directed bench for the dual prefetch buffer controller: a cache model
// whose byte value is a function of its address, a one-entry BTB model and
// one task per scenario.
module tb_dual_prefetch_ctl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic         rsp_valid = 1'b0;
    logic [255:0] rsp_data;
    logic         btb_hit, btb_taken;
    logic [31:0]  btb_target;
    logic [4:0]   btb_brk_off;
    logic         dec_valid;
    logic [127:0] dec_bytes;
    logic [4:0]   dec_count;
    logic [4:0]   dec_consume = 5'd0;
    logic         redirect = 1'b0;
    logic [31:0]  redirect_addr = 32'h0;

    logic         bt_en = 1'b0;
    logic         bt_tk = 1'b0;
    logic [31:0]  bt_line = 32'h0;
    logic [31:0]  bt_tgt = 32'h0;
    logic [4:0]   bt_off = 5'd0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dual_prefetch_ctl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .btb_hit(btb_hit), .btb_taken(btb_taken), .btb_target(btb_target),
        .btb_brk_off(btb_brk_off), .dec_valid(dec_valid), .dec_bytes(dec_bytes),
        .dec_count(dec_count), .dec_consume(dec_consume),
        .redirect(redirect), .redirect_addr(redirect_addr)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [127:0] exp_win(input logic [31:0] a, input int n);
        logic [127:0] v = '0;
        for (int j = 0; j < n; j++) v[8*j +: 8] = mem_byte(a + 32'(j));
        return v;
    endfunction

    // Cache model: line contents for the requested address.
    always_comb begin
        for (int k = 0; k < 32; k++) rsp_data[8*k +: 8] = mem_byte(req_addr + 32'(k));
    end

    // One-entry BTB model.
    always_comb begin
        btb_hit     = bt_en && (req_addr == bt_line);
        btb_taken   = bt_tk;
        btb_target  = bt_tgt;
        btb_brk_off = bt_off;
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_win(input string req, input logic [31:0] a, input int n);
        #1;
        check(dec_count == 5'(n), req, 128'(dec_count), 128'(n));
        check(dec_bytes == exp_win(a, n), req, dec_bytes, exp_win(a, n));
        check(dec_valid == (n != 0), req, 128'(dec_valid), 128'(n != 0));
    endtask

    task automatic chk_req(input string req, input bit v, input logic [31:0] a);
        #1;
        check(req_valid == v, req, 128'(req_valid), 128'(v));
        check(req_addr == a, req, 128'(req_addr), 128'(a));
    endtask

    task automatic fill_one();
        rsp_valid = 1'b1;
        tick();
        rsp_valid = 1'b0;
    endtask

    task automatic consume(input int n);
        dec_consume = 5'(n);
        tick();
        dec_consume = 5'd0;
    endtask

    task automatic do_redirect(input logic [31:0] a, input bit with_rsp);
        redirect = 1'b1;
        redirect_addr = a;
        rsp_valid = with_rsp;
        tick();
        redirect = 1'b0;
        rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk_req("R1 reset request", 1'b1, 32'h0);
        chk_win("R1 reset output", 32'h0, 0);
    endtask

    task automatic t_stall_and_fill();
        repeat (3) tick();
        chk_req("R2 hold while waiting", 1'b1, 32'h0);
        chk_win("R2 nothing before response", 32'h0, 0);
        fill_one();
        chk_win("R5 first window", 32'h0, 16);
        chk_req("R3 R4 full buffer blocks, next line", 1'b0, 32'h20);
    endtask

    task automatic t_consume();
        consume(5);
        chk_win("R6 advance by 5", 32'h5, 16);
        consume(16);
        chk_win("R5 clipped tail", 32'h15, 11);
        consume(11);
        chk_win("R6 drained", 32'h0, 0);
        chk_req("R6 R4 refill request", 1'b1, 32'h20);
    endtask

    task automatic t_redirect();
        do_redirect(32'h1234, 1'b1);
        chk_win("R11 flushed and response dropped", 32'h0, 0);
        chk_req("R11 restart line", 1'b1, 32'h1220);
        fill_one();
        chk_win("R11 entry offset", 32'h1234, 12);
    endtask

    task automatic t_taken();
        do_redirect(32'h2000, 1'b0);
        bt_en = 1'b1; bt_tk = 1'b1; bt_line = 32'h2000; bt_off = 5'd9; bt_tgt = 32'h3047;
        fill_one();
        chk_win("R7 cut after branch", 32'h2000, 10);
        chk_req("R7 target request into other buffer", 1'b1, 32'h3040);
        fill_one();
        chk_win("R7 old bytes still read", 32'h2000, 10);
        chk_req("R3 both full", 1'b0, 32'h3060);
        consume(10);
        chk_win("R9 R8 handoff at target", 32'h3047, 16);
        chk_req("R3 target buffer full", 1'b0, 32'h3060);
        bt_en = 1'b0;
        consume(16);
        chk_win("R6 target tail", 32'h3057, 9);
        consume(9);
        chk_req("R4 sequential after target", 1'b1, 32'h3060);
        fill_one();
        chk_win("R4 next line same buffer", 32'h3060, 16);
    endtask

    task automatic t_not_taken();
        do_redirect(32'h4000, 1'b0);
        bt_en = 1'b1; bt_tk = 1'b0; bt_line = 32'h4000; bt_off = 5'd3; bt_tgt = 32'h7000;
        fill_one();
        chk_win("R10 hit not taken full line", 32'h4000, 16);
        chk_req("R10 hit not taken sequential", 1'b0, 32'h4020);
        consume(16);
        chk_win("R10 no cut at branch", 32'h4010, 16);
        do_redirect(32'h5010, 1'b0);
        bt_tk = 1'b1; bt_line = 32'h5000; bt_off = 5'd4; bt_tgt = 32'h6000;
        fill_one();
        chk_win("R10 branch before entry ignored", 32'h5010, 16);
        chk_req("R10 stays sequential", 1'b0, 32'h5020);
        bt_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_stall_and_fill();
        t_consume();
        t_redirect();
        t_taken();
        t_not_taken();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule